// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the command path of a synchronous DRAM device model or a memory controller's own shadow logic. On every rising clock edge it samples the select, the row strobe, the column strobe, the write enable, the clock enable, the bank index and the address bit that carries the precharge option. From these it produces a one-hot command vector.

Next to that vector it keeps an open or idle flag for each bank. It raises a one-cycle illegal pulse when the command does not suit the current state of its bank. It also reports two qualifiers taken from the option bit. The first is auto-precharge, which applies to reads and writes. The second is precharge-all, which applies to precharge.

A read or write that requests auto-precharge leaves its bank open until an external burst-done strobe names that bank. The bank then closes. All outputs are registered. Each one shows the command sampled at the previous edge and the bank state after that command took effect.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While `sel_n` is high at an edge, the decoded command is no-operation (bit 0 of `cmd_out`), whatever the other pins are, and no bank changes state.
- R2: With `sel_n` low, the pattern {`row_n`,`col_n`,`wen_n`} decodes to one `cmd_out` bit: 011 activate (bit 1), 101 read (bit 2), 100 write (bit 3), 010 precharge (bit 4), 000 mode set (bit 7), 110 burst stop (bit 8), 111 no-operation (bit 0). Exactly one bit is ever set.
- R3: Pattern 001 decodes as auto-refresh (bit 4+1 = bit 5) when `clk_en` was high at the previous edge and is high now. It decodes as self-refresh entry (bit 6) when `clk_en` was high before and is low now. If `clk_en` was low at the previous edge, the command is no-operation.
- R4: Activate to an idle bank opens it. Activate to an open bank pulses `illegal` and leaves every bank unchanged.
- R5: Read or write to an idle bank pulses `illegal` and changes nothing. To an open bank it is legal. `auto_pre` equals `ap_bit` for read and write, and is 0 for any other command.
- R6: Precharge with `ap_bit` low closes the selected bank. With `ap_bit` high it closes all banks and sets `pre_all`. Precharge of an idle bank is legal.
- R7: Auto-refresh or self-refresh entry while any bank is open pulses `illegal`. After a legal refresh, every bank is idle.
- R8: A legal read or write with `ap_bit` high marks its bank pending. A `burst_done` pulse whose `burst_done_bank` names a pending bank closes that bank. A pulse naming a bank that is not pending has no effect. A precharge clears the pending mark of every bank it closes.
- R9: Outputs change one clock after the sampling edge. In reset, `cmd_out` shows no-operation, the flags are 0 and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Device select, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| clk_en | input | 1 | Clock enable |
| bank | input | BA_W | Bank index for the command |
| ap_bit | input | 1 | Precharge option bit (auto-precharge or all banks) |
| burst_done | input | 1 | Burst-complete strobe |
| burst_done_bank | input | BA_W | Bank whose burst completed |
| cmd_out | output | 9 | One-hot decoded command |
| illegal | output | 1 | Command illegal for the current bank state |
| auto_pre | output | 1 | Read or write with auto-precharge |
| pre_all | output | 1 | Precharge of all banks |
| bank_open | output | NUM_BANKS | Per-bank open flag |

## Verification
The assertions assume a few things about the inputs. A `burst_done` pulse never falls in the same cycle as a read, write or activate aimed at the bank it names. Inputs are stable around the rising edge. Under these assumptions, the only thing that can change the bank vector while an illegal activate is being reported is a completion pulse. The stimulus drives all pins on the falling edge. It issues completion pulses only in cycles whose command is a no-operation or targets another bank, so every run stays inside these assumptions.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

   // Bit positions of the one-hot command vector
   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_WR   = 4'd3,
      CMD_PRE  = 4'd4,
      CMD_REF  = 4'd5,
      CMD_SREF = 4'd6,
      CMD_MRS  = 4'd7,
      CMD_BST  = 4'd8
   } cmd_idx_e;

   localparam int unsigned NUM_CMDS = 9;

   typedef logic [NUM_CMDS-1:0] cmd_vec_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_cmd_pkg::*;
(
   input  logic     sel_n,
   input  logic     row_n,
   input  logic     col_n,
   input  logic     wen_n,
   input  logic     clk_en,
   input  logic     clk_en_prev,
   output cmd_vec_t cmd
);

   cmd_idx_e idx;

   always_comb begin
      idx = CMD_NOP;
      // a clock that was suspended at the last edge takes no command
      if (clk_en_prev && !sel_n) begin
         case ({row_n, col_n, wen_n})
            3'b011:  idx = CMD_ACT;
            3'b101:  idx = CMD_RD;
            3'b100:  idx = CMD_WR;
            3'b010:  idx = CMD_PRE;
            3'b001:  idx = clk_en ? CMD_REF : CMD_SREF;
            3'b000:  idx = CMD_MRS;
            3'b110:  idx = CMD_BST;
            default: idx = CMD_NOP;
         endcase
      end
   end

   always_comb begin
      cmd = '0;
      cmd[idx] = 1'b1;
   end

endmodule

// File: rtl/sdram_cmd_legal.sv
module sdram_cmd_legal #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BA_W      = 2
) (
   input  logic                 is_act,
   input  logic                 is_rdwr,
   input  logic                 is_refresh,
   input  logic [BA_W-1:0]      bank,
   input  logic [NUM_BANKS-1:0] bank_open,
   output logic                 illegal
);

   logic sel_open;
   logic any_open;

   assign sel_open = bank_open[bank];
   assign any_open = |bank_open;

   assign illegal = (is_act     &&  sel_open) ||
                    (is_rdwr    && !sel_open) ||
                    (is_refresh &&  any_open);

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BA_W      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 is_act,
   input  logic                 is_rdwr,
   input  logic                 is_pre,
   input  logic                 illegal,
   input  logic [BA_W-1:0]      bank,
   input  logic                 ap_bit,
   input  logic                 burst_done,
   input  logic [BA_W-1:0]      burst_done_bank,
   output logic [NUM_BANKS-1:0] bank_open
);

   logic [NUM_BANKS-1:0] pend;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      logic open_set;
      logic pre_hit;
      logic ap_set;
      logic done_hit;

      assign hit      = (bank == BA_W'(g));
      assign open_set = is_act && !illegal && hit;
      assign pre_hit  = is_pre && (ap_bit || hit);
      assign ap_set   = is_rdwr && ap_bit && !illegal && hit;
      assign done_hit = burst_done && (burst_done_bank == BA_W'(g)) && pend[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_open[g] <= 1'b0;
            pend[g]      <= 1'b0;
         end else begin
            if (pre_hit || done_hit)
               bank_open[g] <= 1'b0;
            else if (open_set)
               bank_open[g] <= 1'b1;
            pend[g] <= ap_set || (pend[g] && !pre_hit && !done_hit);
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_cmd_pkg::*;
#(
   parameter  int unsigned NUM_BANKS = 4,
   localparam int unsigned BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic                 row_n,
   input  logic                 col_n,
   input  logic                 wen_n,
   input  logic                 clk_en,
   input  logic [BA_W-1:0]      bank,
   input  logic                 ap_bit,
   input  logic                 burst_done,
   input  logic [BA_W-1:0]      burst_done_bank,
   output logic [NUM_CMDS-1:0]  cmd_out,
   output logic                 illegal,
   output logic                 auto_pre,
   output logic                 pre_all,
   output logic [NUM_BANKS-1:0] bank_open
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("sdram_cmd_tracker: NUM_BANKS must be a power of two, at least 2");
   end

   logic     clk_en_prev;
   cmd_vec_t cmd_d;
   logic     is_act, is_rdwr, is_pre, is_refresh;
   logic     illegal_d;

   always_ff @(posedge clk) begin
      if (!rst_n) clk_en_prev <= 1'b1;
      else        clk_en_prev <= clk_en;
   end

   sdram_cmd_decode u_decode (
      .sel_n       (sel_n),
      .row_n       (row_n),
      .col_n       (col_n),
      .wen_n       (wen_n),
      .clk_en      (clk_en),
      .clk_en_prev (clk_en_prev),
      .cmd         (cmd_d)
   );

   assign is_act     = cmd_d[CMD_ACT];
   assign is_rdwr    = cmd_d[CMD_RD] | cmd_d[CMD_WR];
   assign is_pre     = cmd_d[CMD_PRE];
   assign is_refresh = cmd_d[CMD_REF] | cmd_d[CMD_SREF];

   sdram_cmd_legal #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_legal (
      .is_act     (is_act),
      .is_rdwr    (is_rdwr),
      .is_refresh (is_refresh),
      .bank       (bank),
      .bank_open  (bank_open),
      .illegal    (illegal_d)
   );

   sdram_bank_state #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
      .clk             (clk),
      .rst_n           (rst_n),
      .is_act          (is_act),
      .is_rdwr         (is_rdwr),
      .is_pre          (is_pre),
      .illegal         (illegal_d),
      .bank            (bank),
      .ap_bit          (ap_bit),
      .burst_done      (burst_done),
      .burst_done_bank (burst_done_bank),
      .bank_open       (bank_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_out  <= NUM_CMDS'(1);
         illegal  <= 1'b0;
         auto_pre <= 1'b0;
         pre_all  <= 1'b0;
      end else begin
         cmd_out  <= cmd_d;
         illegal  <= illegal_d;
         auto_pre <= is_rdwr && ap_bit;
         pre_all  <= is_pre && ap_bit;
      end
   end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
   import sdram_cmd_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BA_W      = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sel_n,
   input logic                 clk_en,
   input logic                 burst_done,
   input logic [NUM_CMDS-1:0]  cmd_out,
   input logic                 illegal,
   input logic                 auto_pre,
   input logic                 pre_all,
   input logic [NUM_BANKS-1:0] bank_open
);

   a_r1_deselect_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(sel_n) |-> cmd_out == NUM_CMDS'(1));

   a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cmd_out) == 1);

   a_r3_suspended_clock_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(rst_n, 2) && !$past(clk_en, 2) |-> cmd_out[CMD_NOP]);

   a_r4_legal_act_changes: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && cmd_out[CMD_ACT] && !illegal |-> bank_open != $past(bank_open));

   a_r4_illegal_act_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && cmd_out[CMD_ACT] && illegal && !$past(burst_done)
      |-> bank_open == $past(bank_open));

   a_r5_auto_pre_on_rdwr: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pre |-> (cmd_out[CMD_RD] || cmd_out[CMD_WR]));

   a_r6_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |-> bank_open == '0);

   a_r7_refresh_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out[CMD_REF] || cmd_out[CMD_SREF]) && !illegal |-> bank_open == '0);

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_n      (sel_n),
   .clk_en     (clk_en),
   .burst_done (burst_done),
   .cmd_out    (cmd_out),
   .illegal    (illegal),
   .auto_pre   (auto_pre),
   .pre_all    (pre_all),
   .bank_open  (bank_open)
);

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;

   localparam int NB = 4;
   localparam int BW = 2;
   localparam int NC = 9;

   // {row_n, col_n, wen_n} patterns
   localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100, P_PRE = 3'b010,
                          P_REF = 3'b001, P_MRS = 3'b000, P_BST = 3'b110, P_NOP = 3'b111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wen_n = 1'b1, clk_en = 1'b1;
   logic [BW-1:0] bank = '0, burst_done_bank = '0;
   logic ap_bit = 1'b0, burst_done = 1'b0;
   logic [NC-1:0] cmd_out;
   logic illegal, auto_pre, pre_all;
   logic [NB-1:0] bank_open;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // reference model state
   bit m_open[NB];
   bit m_pend[NB];
   bit m_cke_prev = 1'b1;

   always #10 clk = ~clk;

   sdram_cmd_tracker #(.NUM_BANKS(NB)) u_sdram_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n),
      .wen_n(wen_n), .clk_en(clk_en), .bank(bank), .ap_bit(ap_bit),
      .burst_done(burst_done), .burst_done_bank(burst_done_bank),
      .cmd_out(cmd_out), .illegal(illegal), .auto_pre(auto_pre),
      .pre_all(pre_all), .bank_open(bank_open)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic logic [NB-1:0] model_vec();
      logic [NB-1:0] v;
      for (int b = 0; b < NB; b++) v[b] = m_open[b];
      return v;
   endfunction

   task automatic compare(string req, logic [NC-1:0] e_cmd, logic e_ill,
                          logic e_ap, logic e_pa, logic [NB-1:0] e_open);
      checks++;
      if (cmd_out !== e_cmd || illegal !== e_ill || auto_pre !== e_ap ||
          pre_all !== e_pa || bank_open !== e_open) begin
         errors++;
         $display("FAIL %s: actual cmd=%b ill=%b ap=%b pa=%b open=%b expected cmd=%b ill=%b ap=%b pa=%b open=%b",
                  req, cmd_out, illegal, auto_pre, pre_all, bank_open,
                  e_cmd, e_ill, e_ap, e_pa, e_open);
      end
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(string req, logic s, logic [2:0] pat, logic ce, int b, logic a,
                       logic dn = 1'b0, int db = 0);
      int idx;
      bit any, ill, ap, pa;
      sel_n = s; {row_n, col_n, wen_n} = pat; clk_en = ce;
      bank = BW'(b); ap_bit = a; burst_done = dn; burst_done_bank = BW'(db);
      @(posedge clk);
      idx = 0;
      if (m_cke_prev && !s) begin
         case (pat)
            P_ACT: idx = 1;
            P_RD:  idx = 2;
            P_WR:  idx = 3;
            P_PRE: idx = 4;
            P_REF: idx = ce ? 5 : 6;
            P_MRS: idx = 7;
            P_BST: idx = 8;
            default: idx = 0;
         endcase
      end
      any = 0;
      for (int k = 0; k < NB; k++) any |= m_open[k];
      ill = (idx == 1 && m_open[b]) || ((idx == 2 || idx == 3) && !m_open[b]) ||
            ((idx == 5 || idx == 6) && any);
      ap = (idx == 2 || idx == 3) && a;
      pa = (idx == 4) && a;
      for (int k = 0; k < NB; k++) begin
         bit pre_k, done_k;
         pre_k  = (idx == 4) && (a || k == b);
         done_k = dn && (db == k) && m_pend[k];
         if (pre_k || done_k) m_open[k] = 0;
         else if (idx == 1 && !ill && k == b) m_open[k] = 1;
         m_pend[k] = ((idx == 2 || idx == 3) && a && !ill && k == b) ||
                     (m_pend[k] && !pre_k && !done_k);
      end
      m_cke_prev = ce;
      @(negedge clk);
      compare(req, NC'(1) << idx, ill, ap, pa, model_vec());
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      compare("R9", NC'(1), 1'b0, 1'b0, 1'b0, '0);
      rst_n = 1'b1;

      step("R1", 1, P_ACT, 1, 0, 0);          // deselect ignores activate pattern
      step("R4", 0, P_ACT, 1, 0, 0);          // open bank 0
      step("R4", 0, P_ACT, 1, 2, 0);          // open bank 2
      step("R4", 0, P_ACT, 1, 0, 0);          // activate open bank: illegal
      step("R5", 0, P_RD,  1, 1, 0);          // read idle bank: illegal
      step("R5", 0, P_WR,  1, 3, 1);          // write idle bank: illegal
      step("R5", 0, P_RD,  1, 0, 0);          // legal read
      step("R5", 0, P_WR,  1, 2, 1);          // write with auto-precharge
      step("R8", 0, P_NOP, 1, 0, 0, 1, 0);    // done for a bank not pending: no effect
      step("R8", 0, P_NOP, 1, 0, 0, 1, 2);    // done closes bank 2
      step("R7", 0, P_REF, 1, 0, 0);          // refresh with bank 0 open: illegal
      step("R7", 0, P_REF, 0, 0, 0);          // self-refresh entry with bank open: illegal
      step("R3", 0, P_ACT, 1, 1, 0);          // clock was suspended: no command
      step("R2", 0, P_MRS, 1, 0, 0);
      step("R2", 0, P_BST, 1, 0, 0);
      step("R2", 0, P_NOP, 1, 0, 0);
      step("R6", 0, P_PRE, 1, 0, 0);          // close bank 0
      step("R6", 0, P_PRE, 1, 0, 0);          // precharge idle bank: legal
      step("R4", 0, P_ACT, 1, 1, 0);
      step("R4", 0, P_ACT, 1, 3, 0);
      step("R1", 1, P_PRE, 1, 0, 1);          // deselected precharge-all: nothing closes
      step("R6", 0, P_PRE, 1, 0, 1);          // precharge all
      step("R7", 0, P_REF, 1, 0, 0);          // legal auto-refresh
      step("R7", 0, P_REF, 0, 0, 0);          // legal self-refresh entry
      step("R3", 0, P_RD,  0, 0, 0);          // held low
      step("R3", 0, P_ACT, 1, 0, 0);          // exit cycle, still no command
      step("R8", 0, P_ACT, 1, 1, 0);
      step("R8", 0, P_RD,  1, 1, 1);          // pending on bank 1
      step("R8", 0, P_PRE, 1, 1, 0);          // precharge clears pending
      step("R8", 0, P_ACT, 1, 1, 0);
      step("R8", 0, P_NOP, 1, 0, 0, 1, 1);    // stale done: bank 1 stays open
      step("R8", 0, P_RD,  1, 1, 1);
      step("R8", 0, P_ACT, 1, 3, 0, 1, 1);    // done closes bank 1 while bank 3 opens
      // sweep every pattern on every bank, with and without the option bit
      for (int b = 0; b < NB; b++)
         for (int p = 0; p < 8; p++)
            for (int a = 0; a < 2; a++)
               step("R2", 0, 3'(p), 1, b, 1'(a));
      step("R9", 0, P_NOP, 1, 0, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule